// File: doc/BRIEF.md
# EEPROM Boot Sequencer

After reset this block acts as a serial master on a four-wire bus and pulls a startup command stream out of an external serial EEPROM. A boot-mode input, captured on the first clock edge after reset is released, decides whether it runs at all. When it runs, it waits a fixed number of master clocks, pulls chip select low, shifts out a read opcode and a start address, and then clocks in data bytes without pause. Each byte goes to the downstream command interpreter as it completes.

All bus timing is counted in master clocks, with no separate bit-rate divider. There is a select delay, a fixed length for each SCLK phase, and a deselect delay after the last falling edge. The stream has no length limit. It ends when outside logic drives the boot-mode input low. The block then finishes the SCLK period in progress, waits out the deselect delay, releases the bus and raises a done flag.

Top module: `eeprom_boot_seq`

## Requirements
- R1: While reset is held, chip select is high, SCLK is low, MOSI is low, the byte strobe is low and done is low.
- R2: If the boot-mode input is low at the first clock edge after reset release, the block stays idle until the next reset: chip select high, SCLK low, done low, no bytes. Later changes of the input have no effect.
- R3: Chip select falls after the 48th clock edge following reset release. Boot-mode changes during that wait have no effect.
- R4: The first SCLK rising edge comes 8 clocks after chip select falls. Every SCLK low phase and every high phase then lasts 8 clocks.
- R5: MOSI carries the opcode 8'h03 and then a 16-bit address of zero, most significant bit first, 24 bits in all. Each bit changes only on an SCLK falling edge. From the 25th rising edge on, MOSI is low.
- R6: SDO is sampled at each SCLK rising edge. The first 24 sampled bits are discarded. Each following group of 8 bits is assembled MSB first into the byte output. The strobe is high for exactly one clock, in the clock where SCLK rises for the byte's last bit.
- R7: A low boot-mode level during the transfer is remembered. SCLK keeps running up to and including its next falling edge and then stays low. Chip select rises 16 clocks after that falling edge. An unfinished byte is dropped.
- R8: Done rises in the same clock in which chip select returns high. Done then stays high, and the bus stays released, until reset whatever the boot-mode input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_mode_i | input | 1 | Boot enable at reset release; a low level later ends the stream |
| sdo_i | input | 1 | Serial data from the EEPROM |
| cs_n_o | output | 1 | EEPROM chip select, active low |
| sclk_o | output | 1 | Serial clock to the EEPROM |
| mosi_o | output | 1 | Serial data to the EEPROM |
| byte_o | output | 8 | Last assembled data byte |
| byte_vld_o | output | 1 | One-clock strobe for byte_o |
| done_o | output | 1 | High once the boot transfer has closed |

## Verification
The bench counts clock edges from reset release. From that count it knows when each result is due: chip select low at edge 48, the k-th SCLK rise at 56+16k and the k-th fall at 64+16k, byte n's strobe at 552+128n, and chip select high with done 16 edges after the last fall. Every timing check samples on the falling clock edge, once at the cycle just before the due edge and once at the due edge, so a result one cycle early or one cycle late is reported. A behavioural EEPROM changes SDO only on SCLK falling edges, and the block latches the stop request one edge after the bench drops the mode input, so the final falling edge can be predicted exactly.

// File: rtl/eeprom_boot_seq.sv
module eeprom_boot_seq #(
  parameter int          SEL_DLY    = 48,
  parameter int          PHASE      = 8,
  parameter int          DESEL_DLY  = 16,
  parameter int          ADDR_W     = 16,
  parameter logic [7:0]  RD_OP      = 8'h03,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_mode_i,
  input  logic       sdo_i,
  output logic       cs_n_o,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       done_o
);

  localparam int CMD_W = 8 + ADDR_W;
  localparam int MAXC  = (SEL_DLY > DESEL_DLY) ? ((SEL_DLY > PHASE) ? SEL_DLY : PHASE)
                                               : ((DESEL_DLY > PHASE) ? DESEL_DLY : PHASE);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int CL_W  = $clog2(CMD_W + 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] SEL_LAST   = CNT_W'(SEL_DLY - 1);
  localparam logic [CNT_W-1:0] PH_LAST    = CNT_W'(PHASE - 1);
  localparam logic [CNT_W-1:0] DESEL_LAST = CNT_W'(DESEL_DLY - 1);
  localparam logic [CL_W-1:0]  CMD_BITS   = CL_W'(CMD_W);
  localparam logic [CL_W-1:0]  CL_ONE     = CL_W'(1);
  localparam logic [CMD_W-1:0] CMD_WORD   = {RD_OP, START_ADDR};

  typedef enum logic [2:0] {S_ARM, S_WAIT, S_XFER, S_TAIL, S_DONE, S_OFF} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [CL_W-1:0]  cmd_left;
  logic [2:0]       bit_idx;
  logic [CMD_W-1:0] tx;
  logic [7:0]       rx;
  logic             cs_q, sclk_q, stop_req, vld_q, done_q;
  logic [7:0]       byte_q;

  wire phase_end = (cnt == PH_LAST);
  wire stop_now  = stop_req | ~boot_mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_ARM;
      cnt      <= '0;
      cmd_left <= CMD_BITS;
      bit_idx  <= '0;
      tx       <= '0;
      rx       <= '0;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b0;
      stop_req <= 1'b0;
      vld_q    <= 1'b0;
      done_q   <= 1'b0;
      byte_q   <= '0;
    end else begin
      vld_q <= 1'b0;
      case (st)
        S_ARM: begin
          if (boot_mode_i) begin
            st  <= S_WAIT;
            cnt <= CNT_ONE;
          end else begin
            st <= S_OFF;
          end
        end
        S_WAIT: begin
          if (cnt == SEL_LAST) begin
            st       <= S_XFER;
            cnt      <= '0;
            cs_q     <= 1'b0;
            tx       <= CMD_WORD;
            cmd_left <= CMD_BITS;
            bit_idx  <= '0;
            stop_req <= 1'b0;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
        S_XFER: begin
          if (!boot_mode_i) stop_req <= 1'b1;
          if (phase_end) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
            if (!sclk_q) begin
              rx <= {rx[6:0], sdo_i};
              if (cmd_left != '0) begin
                cmd_left <= cmd_left - CL_ONE;
              end else begin
                bit_idx <= bit_idx + 3'd1;
                if (bit_idx == 3'd7) begin
                  byte_q <= {rx[6:0], sdo_i};
                  vld_q  <= 1'b1;
                end
              end
            end else begin
              tx <= tx << 1;
              if (stop_now) st <= S_TAIL;
            end
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
        S_TAIL: begin
          if (cnt == DESEL_LAST) begin
            cs_q   <= 1'b1;
            done_q <= 1'b1;
            st     <= S_DONE;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign cs_n_o     = cs_q;
  assign sclk_o     = sclk_q;
  assign mosi_o     = ~cs_q & tx[CMD_W-1];
  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;
  assign done_o     = done_q;

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  // R4
  sclk_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_o) |-> !cs_n_o);

  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);

  // R6
  strobe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> $rose(sclk_o));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  // R8
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && !sclk_o && !byte_vld_o));

  // R7
  stop_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> !sclk_o);

endmodule

// File: tb/eeprom_boot_seq_bench.sv
module eeprom_boot_seq_bench;
  logic clk = 0, rst_n = 0, boot_mode = 0, sdo = 1;
  wire cs_n, sclk, mosi, vld, done;
  wire [7:0] data;

  eeprom_boot_seq u_eeprom_boot_seq (
    .clk(clk), .rst_n(rst_n), .boot_mode_i(boot_mode), .sdo_i(sdo),
    .cs_n_o(cs_n), .sclk_o(sclk), .mosi_o(mosi), .byte_o(data),
    .byte_vld_o(vld), .done_o(done));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, rc = 0, nb = 0, mosi_bad = 0;
  logic [23:0] cmd_cap;
  logic [7:0]  got [16];
  int          gotc [16];

  function automatic logic [7:0] sb(input int n);
    return 8'(((n * 89) + 60) ^ 129);
  endfunction

  always @(posedge clk) if (rst_n) cyc++;

  always @(posedge sclk) begin
    if (rc < 24) cmd_cap = {cmd_cap[22:0], mosi};
    else if (mosi) mosi_bad++;
    rc++;
  end

  always @(negedge sclk) begin
    if (rc >= 24) begin
      logic [7:0] v;
      v = sb((rc - 24) / 8);
      sdo = v[7 - ((rc - 24) % 8)];
    end else sdo = 1'b1;
  end

  always @(negedge clk) if (rst_n && vld) begin
    if (nb < 16) begin got[nb] = data; gotc[nb] = cyc; end
    nb++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 0; boot_mode = mode; sdo = 1;
    repeat (3) @(negedge clk);
    rc = 0; cmd_cap = '0; mosi_bad = 0; nb = 0; cyc = 0;
    // R1
    chk(cs_n && !sclk && !mosi && !vld && !done, "R1 reset outputs",
        {cs_n, sclk, mosi, vld, done}, 5'b10000);
    rst_n = 1;
  endtask

  task automatic t_no_boot;
    int bad = 0;
    do_reset(1'b0);
    wait_cyc(5);
    boot_mode = 1;
    while (cyc < 700) begin
      @(negedge clk);
      if (!cs_n || sclk || done) bad++;
    end
    // R2
    chk(bad == 0, "R2 idle bus", bad, 0);
    chk(nb == 0, "R2 no bytes", nb, 0);
  endtask

  task automatic t_full_boot;
    int bad = 0;
    do_reset(1'b1);
    wait_cyc(47); chk(cs_n == 1, "R3 select before 48", cs_n, 1);
    wait_cyc(48); chk(cs_n == 0, "R3 select at 48", cs_n, 0);
    wait_cyc(55); chk(sclk == 0, "R4 first rise early", sclk, 0);
    wait_cyc(56); chk(sclk == 1, "R4 first rise", sclk, 1);
    wait_cyc(63); chk(sclk == 1, "R4 high phase", sclk, 1);
    wait_cyc(64); chk(sclk == 0, "R4 first fall", sclk, 0);
    wait_cyc(71); chk(sclk == 0, "R4 low phase", sclk, 0);
    wait_cyc(72); chk(sclk == 1, "R4 second rise", sclk, 1);
    wait_cyc(810);
    boot_mode = 0;
    wait_cyc(815); chk(sclk == 1, "R7 clock continues", sclk, 1);
    wait_cyc(816); chk(sclk == 0, "R7 final fall", sclk, 0);
    wait_cyc(831); chk(cs_n == 0 && !done, "R7 deselect early", {cs_n, done}, 0);
    wait_cyc(832);
    chk(cs_n == 1, "R7 deselect at 16", cs_n, 1);
    chk(done == 1, "R8 done with deselect", done, 1);
    // R5
    chk(cmd_cap == 24'h030000, "R5 command word", cmd_cap, 24'h030000);
    chk(mosi_bad == 0, "R5 mosi low after command", mosi_bad, 0);
    // R6
    chk(nb == 3, "R6 byte count", nb, 3);
    for (int i = 0; i < 3; i++) begin
      chk(got[i] == sb(i), "R6 byte value", got[i], sb(i));
      chk(gotc[i] == 552 + 128 * i, "R6 strobe cycle", gotc[i], 552 + 128 * i);
    end
    while (cyc < 1100) begin
      @(negedge clk);
      if (cyc == 900) boot_mode = 1;
      if (!cs_n || sclk || !done) bad++;
    end
    // R8
    chk(bad == 0, "R8 released after done", bad, 0);
    chk(nb == 3, "R8 no bytes after done", nb, 3);
  endtask

  task automatic t_early_stop;
    do_reset(1'b1);
    wait_cyc(10); boot_mode = 0;
    wait_cyc(30); boot_mode = 1;
    wait_cyc(48); chk(cs_n == 0, "R3 wait ignores mode", cs_n, 0);
    wait_cyc(60); boot_mode = 0;
    wait_cyc(63); chk(sclk == 1, "R7 early high phase", sclk, 1);
    wait_cyc(64); chk(sclk == 0, "R7 early final fall", sclk, 0);
    wait_cyc(79); chk(cs_n == 0, "R7 early deselect wait", cs_n, 0);
    wait_cyc(80);
    chk(cs_n == 1 && done == 1, "R8 early done", {cs_n, done}, 3);
    chk(mosi == 0, "R5 mosi idle after stop", mosi, 0);
    wait_cyc(200);
    chk(rc == 1, "R7 one clock pulse", rc, 1);
    chk(nb == 0, "R7 no bytes", nb, 0);
  endtask

  task automatic t_mid_byte_stop;
    do_reset(1'b1);
    wait_cyc(600); boot_mode = 0;
    wait_cyc(608); chk(sclk == 0, "R7 mid byte fall", sclk, 0);
    wait_cyc(623); chk(cs_n == 0, "R7 mid byte wait", cs_n, 0);
    wait_cyc(624); chk(cs_n == 1, "R7 mid byte deselect", cs_n, 1);
    wait_cyc(800);
    chk(nb == 1, "R7 partial byte dropped", nb, 1);
    chk(got[0] == sb(0), "R6 first byte", got[0], sb(0));
    chk(rc == 35, "R7 rises before stop", rc, 35);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_no_boot();
    t_full_boot();
    t_early_stop();
    t_mid_byte_stop();
    do_reset(1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule